// File: doc/BRIEF.md
# Snooping Write-Invalidate Coherence Controller

This block models a small bus-based multiprocessor memory system. Each processor port has its own direct-mapped cache controller, and a shared memory sits behind one common bus. Every cache line is held in one of three states: invalid, valid-clean or dirty. A processor issues a read or a write with a valid/ready handshake. Hits are served locally. Misses, and writes to shared copies, win the bus through a round-robin arbiter and complete as one atomic bus transaction.

Every controller watches the transactions of the others. A plain read transaction that finds a remote dirty copy takes its data from that cache, not from memory, and the same data also refreshes memory. An ownership request (read-for-ownership or kill) removes every other copy of the block. A dirty line that must make room for a new block is first written back to memory as a transaction of its own. The memory model has a combinational read and updates one cycle later. At reset, word `a` holds `(7*a + 3) mod 2^DW`.

Top module: `snoop_coherence_system`

## Requirements
- R1: A processor read of a block that is not present issues a bus read (command code 1). The line becomes valid-clean (state code 1) and the returned data is the latest value written to that address.
- R2: When a read or read-for-ownership transaction finds a dirty copy in another cache, that cache supplies the data (`bus_supplied_o`=1) and memory takes the same value. A plain read drops the supplier to valid-clean. With no dirty copy, memory supplies the data.
- R3: A write hit on a dirty line (state code 2) completes with no bus transaction, and the line stays dirty.
- R4: A write hit on a valid-clean line issues a kill transaction (command code 3). Every other copy becomes invalid (state code 0) and the local line becomes dirty.
- R5: A write miss issues a read-for-ownership (command code 2). Other copies become invalid and the local line ends dirty.
- R6: A read hit completes with no bus transaction and changes no line state.
- R7: A miss whose victim line is dirty first issues a write-back (command code 4) of the victim's address and data, then the fill. A clean or invalid victim causes no write-back.
- R8: At most one cache owns the bus per cycle. Among simultaneous requesters, the cache after the most recent grantee in cyclic order wins.
- R9: No block is dirty in one cache while valid in any other cache.
- R10: After reset every line is invalid and memory word `a` equals `(7*a+3) mod 2^DW`. The line index is the low `log2(NLINES)` address bits, and the state of cache `c` line `l` sits at `line_state_o[(c*NLINES+l)*2 +: 2]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_valid | input | NCACHE | Request valid, one bit per processor |
| cpu_write | input | NCACHE | 1 = write, 0 = read |
| cpu_addr | input | NCACHE*AW | Word address per processor |
| cpu_wdata | input | NCACHE*DW | Write data per processor |
| cpu_ready | output | NCACHE | Request completes at the next clock edge |
| cpu_rdata | output | NCACHE*DW | Read data, valid while ready is high |
| bus_valid_o | output | 1 | A bus transaction occurs this cycle |
| bus_cmd_o | output | 3 | Command: 1 read, 2 read-for-ownership, 3 kill, 4 write-back |
| bus_src_o | output | SRCW | Index of the owning cache |
| bus_addr_o | output | AW | Transaction address |
| bus_supplied_o | output | 1 | A remote dirty cache supplied the data |
| line_state_o | output | NCACHE*NLINES*2 | Per-line coherence state of every cache |

## Verification
The assertions assume that each processor keeps at most one request outstanding and holds its address, data and direction steady from the moment it raises valid until the clock edge where ready is high. They also assume that every cache sharing the memory is attached to this one bus, so no copy changes outside the snooped transactions. The driver changes inputs only on falling edges and releases valid only after the completing edge. Random traffic runs one request at a time, so the latest-written value of each address is unambiguous. Simultaneous requests are used only on distinct addresses, to test arbitration order.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LS_INV   = 2'd0,
    LS_CLEAN = 2'd1,
    LS_DIRTY = 2'd2
  } line_st_e;

  typedef enum logic [2:0] {
    BC_IDLE  = 3'd0,
    BC_READ  = 3'd1,
    BC_RDINV = 3'd2,
    BC_KILL  = 3'd3,
    BC_WBACK = 3'd4
  } bus_cmd_e;

  // Memory contents after reset.
  function automatic int unsigned mem_seed(input int unsigned a);
    return a * 7 + 3;
  endfunction

  // Width of a cache index on the bus.
  function automatic int src_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/coh_rr_arbiter.sv
module coh_rr_arbiter #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int PW = coh_pkg::src_width(N);

  logic [PW-1:0] ptr_q;
  logic [PW-1:0] win;
  logic          found;

  always_comb begin
    int j;
    grant = '0;
    found = 1'b0;
    win   = '0;
    for (int k = 0; k < N; k++) begin
      j = (int'(ptr_q) + k) % N;
      if (!found && req[j]) begin
        grant[j] = 1'b1;
        win      = PW'(j);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (found)  ptr_q <= (int'(win) == N - 1) ? '0 : win + PW'(1);
  end

  for (genvar i = 0; i < N; i++) begin : g_chk
    // R8: the same cache is not granted twice in a row while another waits
    a_r8_rotate: assert property (@(posedge clk) disable iff (!rst_n)
      grant[i] |=> !(grant[i] && ((req & ~(N'(1) << i)) != '0)));
  end
endmodule

// File: rtl/coh_cache_ctrl.sv
module coh_cache_ctrl
  import coh_pkg::*;
#(
  parameter int ID     = 0,
  parameter int NCACHE = 2,
  parameter int AW     = 6,
  parameter int DW     = 8,
  parameter int NLINES = 4
) (
  input  logic                                   clk,
  input  logic                                   rst_n,
  input  logic                                   cpu_valid,
  input  logic                                   cpu_write,
  input  logic [AW-1:0]                          cpu_addr,
  input  logic [DW-1:0]                          cpu_wdata,
  output logic                                   cpu_ready,
  output logic [DW-1:0]                          cpu_rdata,
  output logic                                   bus_req,
  output bus_cmd_e                               req_cmd,
  output logic [AW-1:0]                          req_addr,
  output logic [DW-1:0]                          req_data,
  input  logic                                   bus_grant,
  input  logic                                   bus_valid,
  input  bus_cmd_e                               bus_cmd,
  input  logic [AW-1:0]                          bus_addr,
  input  logic [coh_pkg::src_width(NCACHE)-1:0]  bus_src,
  input  logic [DW-1:0]                          bus_rdata,
  output logic                                   snp_supply,
  output logic [DW-1:0]                          snp_data,
  output logic [NLINES*2-1:0]                    line_st_o,
  output logic [NLINES*(AW-$clog2(NLINES))-1:0]  line_tag_o
);
  localparam int IDXW = $clog2(NLINES);
  localparam int TAGW = AW - IDXW;
  localparam int SRCW = src_width(NCACHE);

  line_st_e        st_q  [NLINES];
  logic [TAGW-1:0] tag_q [NLINES];
  logic [DW-1:0]   dat_q [NLINES];

  logic [IDXW-1:0] c_idx, s_idx;
  logic [TAGW-1:0] c_tag, s_tag;
  logic            hit, local_ok, local_done, victim_dirty, snoop_act, grant_done;

  assign c_idx = cpu_addr[IDXW-1:0];
  assign c_tag = cpu_addr[AW-1:IDXW];
  assign s_idx = bus_addr[IDXW-1:0];
  assign s_tag = bus_addr[AW-1:IDXW];

  // Named events used by the datapath and the assertions
  assign hit          = (st_q[c_idx] != LS_INV) && (tag_q[c_idx] == c_tag);
  assign local_ok     = hit && (!cpu_write || st_q[c_idx] == LS_DIRTY);
  assign snoop_act    = bus_valid && (bus_src != SRCW'(ID)) &&
                        (st_q[s_idx] != LS_INV) && (tag_q[s_idx] == s_tag);
  // a local write waits one cycle if a snoop touches the cache this cycle
  assign local_done   = cpu_valid && local_ok && !(cpu_write && snoop_act);
  assign victim_dirty = !hit && (st_q[c_idx] == LS_DIRTY);
  assign bus_req      = cpu_valid && !local_ok;
  assign grant_done   = bus_grant && (req_cmd != BC_WBACK);

  always_comb begin
    req_addr = cpu_addr;
    req_data = cpu_wdata;
    if (victim_dirty) begin
      req_cmd  = BC_WBACK;
      req_addr = {tag_q[c_idx], c_idx};
      req_data = dat_q[c_idx];
    end else if (!cpu_write) req_cmd = BC_READ;
    else if (hit)            req_cmd = BC_KILL;
    else                     req_cmd = BC_RDINV;
  end

  assign cpu_ready  = local_done || grant_done;
  assign cpu_rdata  = hit ? dat_q[c_idx] : bus_rdata;
  assign snp_supply = snoop_act && (st_q[s_idx] == LS_DIRTY) &&
                      (bus_cmd == BC_READ || bus_cmd == BC_RDINV);
  assign snp_data   = dat_q[s_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NLINES; l++) begin
        st_q[l]  <= LS_INV;
        tag_q[l] <= '0;
        dat_q[l] <= '0;
      end
    end else begin
      if (bus_grant) begin
        case (req_cmd)
          BC_WBACK: st_q[c_idx] <= LS_INV;
          BC_READ: begin
            tag_q[c_idx] <= c_tag;
            dat_q[c_idx] <= bus_rdata;
            st_q[c_idx]  <= LS_CLEAN;
          end
          BC_RDINV: begin
            tag_q[c_idx] <= c_tag;
            dat_q[c_idx] <= cpu_wdata;
            st_q[c_idx]  <= LS_DIRTY;
          end
          BC_KILL: begin
            dat_q[c_idx] <= cpu_wdata;
            st_q[c_idx]  <= LS_DIRTY;
          end
          default: ;
        endcase
      end else if (local_done && cpu_write) begin
        dat_q[c_idx] <= cpu_wdata;
      end
      if (snoop_act) begin
        if (bus_cmd == BC_READ) begin
          if (st_q[s_idx] == LS_DIRTY) st_q[s_idx] <= LS_CLEAN;
        end else if (bus_cmd == BC_RDINV || bus_cmd == BC_KILL) begin
          st_q[s_idx] <= LS_INV;
        end
      end
    end
  end

  for (genvar l = 0; l < NLINES; l++) begin : g_out
    assign line_st_o[l*2 +: 2]        = st_q[l];
    assign line_tag_o[l*TAGW +: TAGW] = tag_q[l];
  end

  // R1: a granted read fills the line clean
  a_r1_fill_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_grant && req_cmd == BC_READ) |=> st_q[$past(c_idx)] == LS_CLEAN);
  // R3: a local write to a dirty line leaves it dirty
  a_r3_dirty_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (local_done && cpu_write) |=> st_q[$past(c_idx)] == LS_DIRTY);
  // R4 / R5: a snooped ownership request removes the local copy
  a_r4_snoop_kill: assert property (@(posedge clk) disable iff (!rst_n)
    (snoop_act && (bus_cmd == BC_KILL || bus_cmd == BC_RDINV))
      |=> st_q[$past(s_idx)] == LS_INV);
  // R6: a read hit with no snoop keeps the line state
  a_r6_read_hit_still: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_valid && !cpu_write && hit && !snoop_act)
      |=> st_q[$past(c_idx)] == $past(st_q[c_idx]));
endmodule

// File: rtl/snoop_coherence_system.sv
module snoop_coherence_system
  import coh_pkg::*;
#(
  parameter int NCACHE = 2,
  parameter int AW     = 6,
  parameter int DW     = 8,
  parameter int NLINES = 4
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic [NCACHE-1:0]                     cpu_valid,
  input  logic [NCACHE-1:0]                     cpu_write,
  input  logic [NCACHE*AW-1:0]                  cpu_addr,
  input  logic [NCACHE*DW-1:0]                  cpu_wdata,
  output logic [NCACHE-1:0]                     cpu_ready,
  output logic [NCACHE*DW-1:0]                  cpu_rdata,
  output logic                                  bus_valid_o,
  output logic [2:0]                            bus_cmd_o,
  output logic [coh_pkg::src_width(NCACHE)-1:0] bus_src_o,
  output logic [AW-1:0]                         bus_addr_o,
  output logic                                  bus_supplied_o,
  output logic [NCACHE*NLINES*2-1:0]            line_state_o
);
  localparam int IDXW  = $clog2(NLINES);
  localparam int TAGW  = AW - IDXW;
  localparam int SRCW  = src_width(NCACHE);
  localparam int WORDS = 1 << AW;

  logic [NCACHE-1:0]        req, grant, supply;
  bus_cmd_e                 req_cmd  [NCACHE];
  logic [AW-1:0]            req_addr [NCACHE];
  logic [DW-1:0]            req_data [NCACHE];
  logic [DW-1:0]            snp_data [NCACHE];
  logic [NLINES*2-1:0]      st_flat  [NCACHE];
  logic [NLINES*TAGW-1:0]   tag_flat [NCACHE];

  logic                     bus_valid, sup_any;
  bus_cmd_e                 bus_cmd;
  logic [AW-1:0]            bus_addr;
  logic [DW-1:0]            bus_wdata, sup_data, bus_rdata;
  logic [SRCW-1:0]          bus_src;
  logic [DW-1:0]            mem_q [WORDS];

  coh_rr_arbiter #(.N(NCACHE)) u_arb (
    .clk(clk), .rst_n(rst_n), .req(req), .grant(grant)
  );

  for (genvar i = 0; i < NCACHE; i++) begin : g_cache
    coh_cache_ctrl #(
      .ID(i), .NCACHE(NCACHE), .AW(AW), .DW(DW), .NLINES(NLINES)
    ) u_cache (
      .clk(clk), .rst_n(rst_n),
      .cpu_valid(cpu_valid[i]), .cpu_write(cpu_write[i]),
      .cpu_addr(cpu_addr[i*AW +: AW]), .cpu_wdata(cpu_wdata[i*DW +: DW]),
      .cpu_ready(cpu_ready[i]), .cpu_rdata(cpu_rdata[i*DW +: DW]),
      .bus_req(req[i]), .req_cmd(req_cmd[i]), .req_addr(req_addr[i]),
      .req_data(req_data[i]), .bus_grant(grant[i]),
      .bus_valid(bus_valid), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
      .bus_src(bus_src), .bus_rdata(bus_rdata),
      .snp_supply(supply[i]), .snp_data(snp_data[i]),
      .line_st_o(st_flat[i]), .line_tag_o(tag_flat[i])
    );
    assign line_state_o[i*NLINES*2 +: NLINES*2] = st_flat[i];
  end

  assign bus_valid = |grant;

  always_comb begin
    bus_cmd   = BC_IDLE;
    bus_addr  = '0;
    bus_wdata = '0;
    bus_src   = '0;
    sup_data  = '0;
    for (int i = 0; i < NCACHE; i++) begin
      if (grant[i]) begin
        bus_cmd   = req_cmd[i];
        bus_addr  = req_addr[i];
        bus_wdata = req_data[i];
        bus_src   = SRCW'(i);
      end
      if (supply[i]) sup_data = sup_data | snp_data[i];
    end
    sup_any   = |supply;
    bus_rdata = sup_any ? sup_data : mem_q[bus_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < WORDS; a++) mem_q[a] <= DW'(mem_seed(a));
    end else if (bus_valid && (bus_cmd == BC_WBACK || sup_any)) begin
      mem_q[bus_addr] <= sup_any ? sup_data : bus_wdata;
    end
  end

  assign bus_valid_o    = bus_valid;
  assign bus_cmd_o      = bus_cmd;
  assign bus_src_o      = bus_src;
  assign bus_addr_o     = bus_addr;
  assign bus_supplied_o = sup_any;

  // R2: at most one cache supplies data on any transaction
  a_r2_one_supplier: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> $onehot0(supply));
  // R7: a write-back lands in memory on the following cycle
  a_r7_wb_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && bus_cmd == BC_WBACK) |=> mem_q[$past(bus_addr)] == $past(bus_wdata));

  for (genvar i = 0; i < NCACHE; i++) begin : g_sw_i
    for (genvar j = i + 1; j < NCACHE; j++) begin : g_sw_j
      for (genvar l = 0; l < NLINES; l++) begin : g_sw_l
        // R9: a block is never dirty in one cache while valid in another
        a_r9_single_writer: assert property (@(posedge clk) disable iff (!rst_n)
          (st_flat[i][l*2 +: 2] != 2'd0 && st_flat[j][l*2 +: 2] != 2'd0 &&
           tag_flat[i][l*TAGW +: TAGW] == tag_flat[j][l*TAGW +: TAGW])
            |-> (st_flat[i][l*2 +: 2] != 2'd2 && st_flat[j][l*2 +: 2] != 2'd2));
      end
    end
  end
endmodule

// File: tb/snoop_coherence_system_tb.sv
module snoop_coherence_system_tb;
  localparam int NC = 2, AW = 6, DW = 8, NL = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NC-1:0]   cpu_valid = '0, cpu_write = '0;
  logic [NC*AW-1:0] cpu_addr = '0;
  logic [NC*DW-1:0] cpu_wdata = '0;
  logic [NC-1:0]   cpu_ready;
  logic [NC*DW-1:0] cpu_rdata;
  logic            bus_valid_o, bus_supplied_o;
  logic [2:0]      bus_cmd_o;
  logic [0:0]      bus_src_o;
  logic [AW-1:0]   bus_addr_o;
  logic [NC*NL*2-1:0] line_state_o;

  always #10 clk = ~clk;

  snoop_coherence_system u_dut (
    .clk(clk), .rst_n(rst_n), .cpu_valid(cpu_valid), .cpu_write(cpu_write),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready),
    .cpu_rdata(cpu_rdata), .bus_valid_o(bus_valid_o), .bus_cmd_o(bus_cmd_o),
    .bus_src_o(bus_src_o), .bus_addr_o(bus_addr_o),
    .bus_supplied_o(bus_supplied_o), .line_state_o(line_state_o)
  );

  int checks = 0, errors = 0;
  logic [DW-1:0] gold [64];

  typedef struct { int c; int a; logic [DW-1:0] d; } exp_t;
  typedef struct { int cmd; int src; int a; int sup; } blog_t;
  exp_t  exp_q[$];
  blog_t blog[$];

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int st(input int c, input int l);
    return int'(line_state_o[(c*NL+l)*2 +: 2]);
  endfunction

  // Monitor: logs bus traffic and compares read data against the scoreboard
  always @(negedge clk) begin
    #3;
    if (rst_n) begin
      if (bus_valid_o)
        blog.push_back('{int'(bus_cmd_o), int'(bus_src_o), int'(bus_addr_o), int'(bus_supplied_o)});
      for (int c = 0; c < NC; c++) begin
        if (cpu_valid[c] && cpu_ready[c] && !cpu_write[c]) begin
          int found;
          found = -1;
          for (int k = 0; k < exp_q.size(); k++)
            if (found < 0 && exp_q[k].c == c) found = k;
          if (found < 0) chk(1'b0, "R1", "unexpected read completion", c, -1);
          else begin
            chk(cpu_rdata[c*DW +: DW] == exp_q[found].d, "R1", "read data",
                int'(cpu_rdata[c*DW +: DW]), int'(exp_q[found].d));
            exp_q.delete(found);
          end
        end
      end
    end
  end

  // Driver: pushes the expectation, then holds the request until it completes
  task automatic op(input int c, input bit wr, input int a, input logic [DW-1:0] d);
    bit done;
    int n;
    @(negedge clk);
    cpu_valid[c] = 1'b1;
    cpu_write[c] = wr;
    cpu_addr[c*AW +: AW]  = AW'(a);
    cpu_wdata[c*DW +: DW] = d;
    if (wr) gold[a] = d;
    else    exp_q.push_back('{c, a, gold[a]});
    n = 0;
    forever begin
      #2;
      done = cpu_ready[c];
      @(posedge clk);
      n++;
      if (done) break;
      if (n > 1000) begin
        chk(1'b0, "R8", "request never completed", c, -1);
        break;
      end
    end
    #1 cpu_valid[c] = 1'b0;
  endtask

  task automatic bus_one(input string req, input int cmd, input int src,
                         input int a, input int sup);
    chk(blog.size() == 1, req, "bus transaction count", blog.size(), 1);
    if (blog.size() == 1) begin
      chk(blog[0].cmd == cmd, req, "bus command", blog[0].cmd, cmd);
      chk(blog[0].src == src, req, "bus owner", blog[0].src, src);
      chk(blog[0].a == a, req, "bus address", blog[0].a, a);
      chk(blog[0].sup == sup, req, "remote supply flag", blog[0].sup, sup);
    end
  endtask

  initial begin
    #(20 * 150000);
    chk(1'b0, "R8", "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int a = 0; a < 64; a++) gold[a] = DW'(a * 7 + 3);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk(line_state_o == '0, "R10", "all lines invalid after reset", int'(line_state_o), 0);

    // R1: cold read miss, memory seed value
    blog.delete(); op(0, 0, 5, '0);
    bus_one("R1", 1, 0, 5, 0);
    chk(st(0, 1) == 1, "R1", "line clean after fill", st(0, 1), 1);
    chk(gold[5] == 8'd38, "R10", "seed of word 5", int'(gold[5]), 38);

    // R6: read hit is silent
    blog.delete(); op(0, 0, 5, '0);
    chk(blog.size() == 0, "R6", "read hit bus count", blog.size(), 0);
    chk(st(0, 1) == 1, "R6", "read hit state", st(0, 1), 1);

    blog.delete(); op(1, 0, 5, '0);
    bus_one("R1", 1, 1, 5, 0);
    chk(st(1, 1) == 1, "R1", "second sharer clean", st(1, 1), 1);

    // R4: write to a shared clean line
    blog.delete(); op(0, 1, 5, 8'hA1);
    bus_one("R4", 3, 0, 5, 0);
    chk(st(0, 1) == 2, "R4", "writer dirty", st(0, 1), 2);
    chk(st(1, 1) == 0, "R4", "other copy invalid", st(1, 1), 0);

    // R3: write to a dirty line
    blog.delete(); op(0, 1, 5, 8'hA2);
    chk(blog.size() == 0, "R3", "dirty write hit bus count", blog.size(), 0);
    chk(st(0, 1) == 2, "R3", "line still dirty", st(0, 1), 2);

    // R2: remote dirty copy supplies a read
    blog.delete(); op(1, 0, 5, '0);
    bus_one("R2", 1, 1, 5, 1);
    chk(st(0, 1) == 1, "R2", "supplier drops to clean", st(0, 1), 1);
    chk(st(1, 1) == 1, "R2", "requester clean", st(1, 1), 1);
    chk(!(st(0, 1) == 2 || st(1, 1) == 2), "R9", "no dirty copy beside a sharer", st(0, 1), 1);

    // R5 and R7: write miss over a clean victim
    blog.delete(); op(1, 1, 9, 8'h33);
    bus_one("R5", 2, 1, 9, 0);
    chk(st(1, 1) == 2, "R5", "write miss ends dirty", st(1, 1), 2);
    chk(st(0, 1) == 1, "R5", "other block in same index untouched", st(0, 1), 1);

    // R5 and R2: write miss served by remote dirty holder
    blog.delete(); op(0, 1, 9, 8'h77);
    bus_one("R5", 2, 0, 9, 1);
    chk(st(1, 1) == 0, "R5", "old owner invalid", st(1, 1), 0);
    chk(st(0, 1) == 2, "R9", "single dirty owner", st(0, 1), 2);

    // R7: dirty victim written back before the fill
    blog.delete(); op(0, 0, 13, '0);
    chk(blog.size() == 2, "R7", "write-back plus fill", blog.size(), 2);
    if (blog.size() == 2) begin
      chk(blog[0].cmd == 4 && blog[0].a == 9, "R7", "write-back of victim", blog[0].cmd, 4);
      chk(blog[1].cmd == 1 && blog[1].a == 13, "R7", "fill after write-back", blog[1].cmd, 1);
    end
    chk(st(0, 1) == 1, "R7", "refilled line clean", st(0, 1), 1);
    blog.delete(); op(1, 0, 9, '0);
    bus_one("R7", 1, 1, 9, 0);

    // R8: simultaneous requests, order follows the last grantee
    blog.delete();
    fork op(0, 0, 2, '0); op(1, 0, 3, '0); join
    chk(blog.size() == 2, "R8", "two transactions", blog.size(), 2);
    if (blog.size() == 2) begin
      chk(blog[0].src == 0, "R8", "first owner", blog[0].src, 0);
      chk(blog[1].src == 1, "R8", "second owner", blog[1].src, 1);
    end
    op(0, 0, 10, '0);
    blog.delete();
    fork op(0, 0, 6, '0); op(1, 0, 7, '0); join
    chk(blog.size() == 2, "R8", "two transactions after rotation", blog.size(), 2);
    if (blog.size() == 2) begin
      chk(blog[0].src == 1, "R8", "rotated first owner", blog[0].src, 1);
      chk(blog[1].src == 0, "R8", "rotated second owner", blog[1].src, 0);
    end

    // Random traffic: every read must see the latest written value (R1, R2, R9)
    for (int i = 0; i < 400; i++) begin
      int c, a;
      bit wr;
      c  = int'($urandom_range(NC - 1, 0));
      a  = int'($urandom_range(15, 0));
      wr = 1'($urandom_range(1, 0));
      op(c, wr, a, DW'($urandom));
    end
    repeat (2) @(negedge clk);
    chk(exp_q.size() == 0, "R1", "all expected reads seen", exp_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule